// File: doc/BRIEF.md
# Byte-Stream Instruction Fetch Unit

This unit feeds an instruction decoder one 8-bit opcode at a time from a memory of 16-bit words, each word packing two instruction bytes. It keeps a word program counter and a one-byte holding register for the unused high half of the last word it read. The even byte is the low half of a word and the odd byte is the high half. A holding register value of zero means the register is empty. Because opcode zero is a no-operation, a zero odd byte costs nothing: the next request simply fetches a fresh word.

Callers pick one of four ways to get the next opcode:
- continue from the holding register;
- fetch the next word and start at its even byte;
- fetch the word at PC plus an offset and deliver only its odd byte, which serves jumps to odd targets;
- either fetch above, but with the interrupt test turned off.

A pending interrupt is only considered when a checked fetch returns its word, and it is taken only when it is also enabled. Taking it suppresses the opcode, steps the PC back by one word and reports whether the interrupted entry was odd.

Top module: `ifu_fetch`

## Requirements
- R1: After reset the PC is 0, the holding register is empty, and no opcode, interrupt or memory read is produced, so the first continue request reads word address 1.
- R2: An even request (req_mode 1) drives mem_rd_en with mem_addr = PC+1 in its own cycle and loads the PC with that address. Memory answers one cycle later, and op_valid with op_byte = low byte of the word follows one cycle after that.
- R3: An even fetch keeps the high byte in the holding register. A later continue request (req_mode 0) with a non-empty register delivers that byte on op_valid in the next cycle, reads no memory and leaves the register empty.
- R4: A continue request with an empty register, including after a word whose high byte is zero, behaves as a checked even fetch of PC+1.
- R5: An odd request (req_mode 2) reads mem_addr = PC+req_offset (modulo the PC width), loads the PC with it, delivers the high byte of that word and leaves the register empty.
- R6: If irq_pending and irq_enable are both high in the cycle a checked fetch's word returns, no opcode is delivered. Instead irq_taken pulses in the next cycle, the PC becomes the fetched address minus 1, the register is emptied, and irq_odd is 1 for an odd fetch and 0 otherwise.
- R7: A pending interrupt that is not enabled, or an enabled one that is not pending, has no effect on delivery.
- R8: A fetch with req_deaf high never takes an interrupt.
- R9: Requests arriving while a fetch is outstanding are ignored, and req_mode 3 is ignored at all times.
- R10: op_valid and irq_taken are single-cycle pulses per event and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Opcode request |
| req_mode | input | 2 | 0 continue, 1 even fetch, 2 odd fetch, 3 ignored |
| req_deaf | input | 1 | Skip the interrupt test on a fetch |
| req_offset | input | PC_W | Word offset added to PC for an odd fetch |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | PC_W | Memory word address |
| mem_rdata | input | 2*BYTE_W | Read data, one cycle after the strobe |
| irq_pending | input | 1 | Interrupt pending |
| irq_enable | input | 1 | Interrupt enabled (wakeup count zero) |
| op_valid | output | 1 | Opcode delivered this cycle |
| op_byte | output | BYTE_W | Delivered opcode |
| irq_taken | output | 1 | Interrupt taken this cycle |
| irq_odd | output | 1 | Interrupted entry was odd |
| pc | output | PC_W | Current word program counter |

## Verification
The hardest case to reach is an interrupt that is pending and enabled in exactly the cycle the fetched word comes back. The stimulus raises both lines before issuing checked even, odd and continue-on-empty fetches, which reaches that cycle on every entry type. It then repeats the same fetches deaf and with only one of the two lines high. A word whose high byte is zero is reached by steering the PC with an odd jump so that the following even fetch lands on it. A random phase mixes modes, offsets and interrupt lines, and it also issues requests into the busy cycle.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  typedef enum logic [1:0] {
    MODE_CONT = 2'd0,
    MODE_EVEN = 2'd1,
    MODE_ODD  = 2'd2,
    MODE_RSVD = 2'd3
  } ifu_mode_e;
endpackage

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
  import ifu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_mode,
  input  logic            req_deaf,
  input  logic [PC_W-1:0] req_offset,
  input  logic            buf_empty,
  input  logic            irq_pending,
  input  logic            irq_enable,
  output logic            mem_rd_en,
  output logic [PC_W-1:0] mem_addr,
  output logic            cont_hit,
  output logic            land,
  output logic            land_odd,
  output logic            take_irq,
  output logic [PC_W-1:0] pc
);
  logic            busy_q, busy_d;
  logic            chk_q, chk_d;
  logic            odd_q, odd_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            accept, start_even, start_odd;

  always_comb begin
    accept     = req_valid && !busy_q;
    start_even = accept && ((req_mode == MODE_EVEN) ||
                            ((req_mode == MODE_CONT) && buf_empty));
    start_odd  = accept && (req_mode == MODE_ODD);
    cont_hit   = accept && (req_mode == MODE_CONT) && !buf_empty;
    mem_rd_en  = start_even || start_odd;
    mem_addr   = start_odd ? (pc_q + req_offset) : (pc_q + PC_W'(1));
    take_irq   = busy_q && chk_q && irq_pending && irq_enable;
    land       = busy_q && !take_irq;
    land_odd   = odd_q;
  end

  always_comb begin
    busy_d = mem_rd_en;
    chk_d  = chk_q;
    odd_d  = odd_q;
    pc_d   = pc_q;
    if (mem_rd_en) begin
      chk_d = (req_mode == MODE_CONT) || !req_deaf;
      odd_d = start_odd;
      pc_d  = mem_addr;
    end else if (take_irq) begin
      pc_d  = pc_q - PC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      chk_q  <= 1'b0;
      odd_q  <= 1'b0;
      pc_q   <= '0;
    end else begin
      busy_q <= busy_d;
      if (mem_rd_en) begin
        chk_q <= chk_d;
        odd_q <= odd_d;
      end
      if (mem_rd_en || take_irq) pc_q <= pc_d;
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/ifu_byte_buf.sv
module ifu_byte_buf #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cont_hit,
  input  logic                land,
  input  logic                land_odd,
  input  logic                take_irq,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  output logic                buf_empty,
  output logic                op_valid,
  output logic [BYTE_W-1:0]   op_byte,
  output logic                irq_taken,
  output logic                irq_odd
);
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [BYTE_W-1:0] opb_q, opb_d;
  logic              opv_q, opv_d;
  logic              irq_q, irq_d;
  logic              iodd_q, iodd_d;
  logic [BYTE_W-1:0] lo_byte, hi_byte;

  always_comb begin
    lo_byte = mem_rdata[BYTE_W-1:0];
    hi_byte = mem_rdata[2*BYTE_W-1:BYTE_W];
    hold_d  = hold_q;
    opb_d   = opb_q;
    opv_d   = 1'b0;
    irq_d   = 1'b0;
    iodd_d  = iodd_q;
    if (cont_hit) begin
      opv_d  = 1'b1;
      opb_d  = hold_q;
      hold_d = '0;
    end
    if (land) begin
      opv_d  = 1'b1;
      opb_d  = land_odd ? hi_byte : lo_byte;
      hold_d = land_odd ? '0 : hi_byte;
    end
    if (take_irq) begin
      irq_d  = 1'b1;
      iodd_d = land_odd;
      hold_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      opb_q  <= '0;
      opv_q  <= 1'b0;
      irq_q  <= 1'b0;
      iodd_q <= 1'b0;
    end else begin
      opv_q <= opv_d;
      irq_q <= irq_d;
      if (cont_hit || land || take_irq) hold_q <= hold_d;
      if (cont_hit || land) opb_q <= opb_d;
      if (take_irq) iodd_q <= iodd_d;
    end
  end

  assign buf_empty = (hold_q == '0);
  assign op_valid  = opv_q;
  assign op_byte   = opb_q;
  assign irq_taken = irq_q;
  assign irq_odd   = iodd_q;
endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch
  import ifu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_mode,
  input  logic                req_deaf,
  input  logic [PC_W-1:0]     req_offset,
  output logic                mem_rd_en,
  output logic [PC_W-1:0]     mem_addr,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  input  logic                irq_pending,
  input  logic                irq_enable,
  output logic                op_valid,
  output logic [BYTE_W-1:0]   op_byte,
  output logic                irq_taken,
  output logic                irq_odd,
  output logic [PC_W-1:0]     pc
);
  logic buf_empty, cont_hit, land, land_odd, take_irq;

  ifu_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_mode(req_mode), .req_deaf(req_deaf),
    .req_offset(req_offset), .buf_empty(buf_empty),
    .irq_pending(irq_pending), .irq_enable(irq_enable),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .cont_hit(cont_hit), .land(land), .land_odd(land_odd),
    .take_irq(take_irq), .pc(pc)
  );

  ifu_byte_buf #(.BYTE_W(BYTE_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .cont_hit(cont_hit), .land(land), .land_odd(land_odd),
    .take_irq(take_irq), .mem_rdata(mem_rdata),
    .buf_empty(buf_empty), .op_valid(op_valid), .op_byte(op_byte),
    .irq_taken(irq_taken), .irq_odd(irq_odd)
  );

  // R10: opcode and interrupt never reported together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && irq_taken));

  // R2: every read resolves into exactly one opcode or one interrupt two cycles on
  a_r2_fetch_resolves: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ##1 (op_valid ^ irq_taken));

  // R6: taking an interrupt steps the PC back by one word
  a_r6_pc_backup: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> (pc == $past(pc) - PC_W'(1)));

  // R8: a deaf fetch cannot end in an interrupt
  a_r8_deaf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && req_deaf && (req_mode != MODE_CONT)) |=> ##1 !irq_taken);

  // R9: no new read is issued in the cycle after a read
  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

// File: tb/ifu_fetch_tb.sv
`timescale 1ns/1ps
module ifu_fetch_tb;
  localparam int PC_W = 16;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic req_deaf = 1'b0;
  logic [PC_W-1:0] req_offset = '0;
  logic mem_rd_en;
  logic [PC_W-1:0] mem_addr;
  logic [2*BYTE_W-1:0] mem_rdata = '0;
  logic irq_pending = 1'b0;
  logic irq_enable = 1'b0;
  logic op_valid;
  logic [BYTE_W-1:0] op_byte;
  logic irq_taken;
  logic irq_odd;
  logic [PC_W-1:0] pc;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ifu_fetch #(.PC_W(PC_W), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_deaf(req_deaf), .req_offset(req_offset), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .irq_pending(irq_pending),
    .irq_enable(irq_enable), .op_valid(op_valid), .op_byte(op_byte),
    .irq_taken(irq_taken), .irq_odd(irq_odd), .pc(pc)
  );

  function automatic logic [15:0] word_of(input logic [PC_W-1:0] a);
    return {a[7:0] ^ 8'hC3, a[7:0] + 8'h01};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= word_of(mem_addr);

  // behavioural reference
  int m_pc = 0, m_buf = 0, m_addr = 0, m_opb = 0;
  bit m_busy = 0, m_odd = 0, m_chk = 0, m_opv = 0, m_irq = 0, m_iodd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_buf = 0; m_busy = 0; m_odd = 0; m_chk = 0;
      m_opv = 0; m_opb = 0; m_irq = 0; m_iodd = 0;
    end else begin
      logic [15:0] w;
      m_opv = 0; m_irq = 0;
      if (m_busy) begin
        m_busy = 0;
        w = word_of(PC_W'(m_addr));
        if (m_chk && irq_pending && irq_enable) begin
          m_irq = 1; m_iodd = m_odd; m_buf = 0;
          m_pc = (m_pc - 1) & 16'hFFFF;
        end else if (m_odd) begin
          m_opv = 1; m_opb = w[15:8]; m_buf = 0;
        end else begin
          m_opv = 1; m_opb = w[7:0]; m_buf = w[15:8];
        end
      end else if (req_valid) begin
        if (req_mode == 2'd0 && m_buf != 0) begin
          m_opv = 1; m_opb = m_buf; m_buf = 0;
        end else if (req_mode != 2'd3) begin
          m_odd = (req_mode == 2'd2);
          m_chk = (req_mode == 2'd0) || !req_deaf;
          m_addr = m_odd ? ((m_pc + req_offset) & 16'hFFFF) : ((m_pc + 1) & 16'hFFFF);
          m_pc = m_addr;
          m_busy = 1;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      bit e_rd;
      int e_addr;
      e_rd = rst_n && !m_busy && req_valid &&
             (req_mode == 2'd1 || req_mode == 2'd2 || (req_mode == 2'd0 && m_buf == 0));
      e_addr = (req_mode == 2'd2) ? ((m_pc + req_offset) & 16'hFFFF) : ((m_pc + 1) & 16'hFFFF);
      chk("mem_rd_en", mem_rd_en, e_rd);
      if (e_rd) chk("mem_addr", mem_addr, e_addr);
      chk("op_valid", op_valid, m_opv);
      if (m_opv) chk("op_byte", op_byte, m_opb);
      chk("irq_taken", irq_taken, m_irq);
      chk("irq_odd", irq_odd, m_iodd);
      chk("pc", pc, m_pc);
    end
  end

  task automatic issue(input logic [1:0] mode, input bit deaf, input int off, input string tag);
    @(negedge clk);
    cur_req = tag;
    req_valid = 1'b1; req_mode = mode; req_deaf = deaf; req_offset = PC_W'(off);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    repeat (2) @(negedge clk);
    issue(2'd0, 0, 0, "R1");            // first continue reads word 1
    issue(2'd0, 0, 0, "R3");            // held high byte
    issue(2'd1, 0, 0, "R2");
    issue(2'd1, 0, 0, "R2");
    issue(2'd0, 0, 0, "R3");
    issue(2'd0, 0, 0, "R4");            // empty -> fetch
    issue(2'd2, 0, 5, "R5");
    issue(2'd2, 0, -3, "R5");
    issue(2'd0, 0, 0, "R4");
    // steer PC so an even fetch lands on a word with high byte zero
    issue(2'd2, 0, 16'hC2 - m_pc, "R5");
    issue(2'd1, 0, 0, "R4");
    issue(2'd0, 0, 0, "R4");            // zero hold -> fetch 0xC4
    issue(2'd3, 0, 7, "R9");            // reserved mode ignored
    issue(2'd0, 0, 0, "R9");
    // request in busy cycle
    @(negedge clk);
    cur_req = "R9";
    req_valid = 1'b1; req_mode = 2'd1; req_deaf = 0;
    @(negedge clk);
    req_mode = 2'd2; req_offset = 16'd40;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    // interrupts
    irq_pending = 1; irq_enable = 1;
    issue(2'd1, 0, 0, "R6");
    issue(2'd2, 0, 9, "R6");
    issue(2'd0, 0, 0, "R6");
    issue(2'd1, 1, 0, "R8");
    issue(2'd2, 1, 4, "R8");
    irq_enable = 0;
    issue(2'd1, 0, 0, "R7");
    issue(2'd0, 0, 0, "R7");
    irq_pending = 0; irq_enable = 1;
    issue(2'd2, 0, 2, "R7");
    irq_enable = 0;
    // random mix, including back-to-back requests
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cur_req = "R10";
      req_valid = ($urandom_range(0, 3) != 0);
      req_mode = 2'($urandom_range(0, 3));
      req_deaf = 1'($urandom_range(0, 1));
      req_offset = PC_W'($urandom_range(0, 20)) - PC_W'(6);
      irq_pending = 1'($urandom_range(0, 1));
      irq_enable = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    req_valid = 0; irq_pending = 0;
    repeat (4) @(negedge clk);
    // reset mid-stream
    cur_req = "R1";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    issue(2'd0, 0, 0, "R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule